// File: doc/BRIEF.md
# Multichannel Wilkinson Rundown Conversion Controller

This block is the digital half of a multichannel charge digitizer built on the rundown principle. The charge on each input capacitor is discharged at a constant rate. The block counts conversion-clock edges for as long as that channel's end-of-rundown comparator reports that the discharge is still going on. The analog integrators and comparators sit outside the block. Each channel reaches it only as a single rundown-active flag.

In common mode, one shared gate starts every channel at the same time. In separate-gate mode, the shared gate is ignored. A start strobe launches the sequence instead, and all channels begin counting after a fixed number of cycles. A fast clear aborts whatever is in progress and zeroes the results. It then holds off any new gate or start for a settling interval. A bus inhibit stops a new conversion from being accepted.

Each channel holds a 10-bit result, or an 8-bit result when the reduced-resolution mode is selected. A result saturates and is marked as overflow when its rundown outlasts the counter. A single end-of-conversion pulse marks the point at which the last channel has finished.

Top module: `wilkinson_conv_ctrl`

## Requirements
- R1: The result of each channel is the number of clock edges, during its conversion, at which that channel's rundown flag was sampled high. Counting starts at the first edge after the conversion begins, and the channel finishes at the first edge where its flag is sampled low. Channels finish independently.
- R2: The controller accepts a gate only when it is idle, common mode is selected (sepGateMode = 0), and inhibit is low. The conversion begins at the edge where the gate is sampled high. From the next cycle, busy is high and the results read zero.
- R3: The width of the counter is fixed by the value of shortMode sampled at acceptance: a maximum of 255 when it is 1, and 1023 when it is 0. Suppose a channel is still active at an edge where its count already equals that maximum. At that edge the count stays at the maximum, the overflow bit of the channel is set, and the channel finishes.
- R4: eoc is a one-cycle pulse. It rises one clock after the edge at which the last channel finishes. busy falls in the same cycle that eoc rises. resultValid rises with eoc and stays high until the next acceptance or fast clear.
- R5: A fast clear sampled high in any state zeroes all results and overflow bits and drops busy and resultValid in the next cycle. Gates and starts are then ignored until the (SETTLE_CYC+1)-th edge after the last edge at which fast clear was high.
- R6: While inhibit is high, neither a gate nor a start is accepted. inhibit has no effect on a conversion that is already running.
- R7: With sepGateMode = 1, the gate is ignored and a start strobe is accepted under the same conditions as in R2. busy rises after the acceptance edge, and the conversion begins START_DLY edges after that edge. In this mode, R1 counts from the conversion start, not from acceptance.
- R8: A gate or start that arrives while busy is ignored. After eoc, the results and overflow bits stay unchanged until the next acceptance or fast clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gateIn | input | 1 | Common gate, used in common mode |
| startIn | input | 1 | Start strobe, used in separate-gate mode |
| fastClear | input | 1 | Abort and clear all channels |
| inhibit | input | 1 | Blocks acceptance of gate or start |
| sepGateMode | input | 1 | 1 selects separate-gate mode |
| shortMode | input | 1 | 1 selects the 8-bit range |
| rundownActive | input | NUM_CH | Per-channel rundown-in-progress flags |
| busy | output | 1 | Conversion accepted and not yet finished |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| resultValid | output | 1 | Results complete and held |
| results | output | NUM_CH*CNT_W | Channel results, channel i at bits [i*CNT_W +: CNT_W] |
| overflow | output | NUM_CH | Per-channel saturation flags |

## Verification
Once a gate is accepted, busy is due one cycle after the acceptance edge. Each count advances one cycle after every counted edge. eoc arrives two cycles after the edge at which the last flag is sampled low: one cycle for the done flag to settle and one for the pulse register. In separate-gate mode, every count is shifted by START_DLY cycles. The bench drives each flag from the number of edges elapsed since the gate or start. It updates a behavioural model on every rising edge and compares all outputs at the following falling edge. This keeps each comparison in the cycle where the result is due. Directed checks then compare each held result with its programmed rundown length, clipped at 255 or 1023.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DELAY,
    ST_CONV
  } ctrl_state_t;

  // strobes from the sequencer to the counter bank
  typedef struct packed {
    logic clrAll;     // fast clear: zero everything
    logic startConv;  // conversion begins: zero counters
    logic runEn;      // counting window open
    logic shortSel;   // reduced range latched at acceptance
  } strobe_t;

endpackage

// File: rtl/wcc_control.sv
module wcc_control
  import wcc_pkg::*;
#(
  parameter int SETTLE_CYC = 250,
  parameter int START_DLY  = 250
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    gateIn,
  input  logic    startIn,
  input  logic    fastClear,
  input  logic    inhibit,
  input  logic    sepGateMode,
  input  logic    shortMode,
  input  logic    allDone,
  output strobe_t strobes,
  output logic    busy,
  output logic    eoc,
  output logic    resultValid
);

  localparam int TMR_MAX = (SETTLE_CYC > START_DLY) ? SETTLE_CYC : START_DLY;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  ctrl_state_t     state;
  logic [TMR_W-1:0] tmr;
  logic            shortReg;
  logic            accept;
  logic            delayDone;

  assign accept    = (state == ST_IDLE) && !inhibit &&
                     (sepGateMode ? startIn : gateIn);
  assign delayDone = (state == ST_DELAY) && (tmr == '0);

  always_comb begin
    strobes.clrAll    = fastClear;
    strobes.startConv = !fastClear && ((accept && !sepGateMode) || delayDone);
    strobes.runEn     = !fastClear && (state == ST_CONV);
    strobes.shortSel  = shortReg;
  end

  assign busy = (state == ST_DELAY) || (state == ST_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tmr         <= '0;
      shortReg    <= 1'b0;
      eoc         <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (fastClear) begin
        state       <= ST_SETTLE;
        tmr         <= TMR_W'(SETTLE_CYC - 1);
        resultValid <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (accept) begin
              resultValid <= 1'b0;
              shortReg    <= shortMode;
              if (sepGateMode) begin
                state <= ST_DELAY;
                tmr   <= TMR_W'(START_DLY - 1);
              end else begin
                state <= ST_CONV;
              end
            end
          end
          ST_SETTLE: begin
            if (tmr == '0) state <= ST_IDLE;
            else           tmr   <= tmr - 1'b1;
          end
          ST_DELAY: begin
            if (tmr == '0) state <= ST_CONV;
            else           tmr   <= tmr - 1'b1;
          end
          ST_CONV: begin
            if (allDone) begin
              state       <= ST_IDLE;
              eoc         <= 1'b1;
              resultValid <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/wcc_datapath.sv
module wcc_datapath
  import wcc_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int CNT_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strobes,
  input  logic [NUM_CH-1:0]       rundownActive,
  output logic [NUM_CH*CNT_W-1:0] results,
  output logic [NUM_CH-1:0]       overflow,
  output logic                    allDone
);

  localparam logic [CNT_W-1:0] FULL_MAX  = '1;
  localparam logic [CNT_W-1:0] SHORT_MAX = CNT_W'((1 << SHORT_W) - 1);

  logic [CNT_W-1:0]  maxVal;
  logic [NUM_CH-1:0] doneVec;

  assign maxVal  = strobes.shortSel ? SHORT_MAX : FULL_MAX;
  assign allDone = &doneVec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        count        <= '0;
        doneVec[ch]  <= 1'b0;
        overflow[ch] <= 1'b0;
      end else if (strobes.clrAll || strobes.startConv) begin
        count        <= '0;
        doneVec[ch]  <= 1'b0;
        overflow[ch] <= 1'b0;
      end else if (strobes.runEn && !doneVec[ch]) begin
        if (!rundownActive[ch]) begin
          doneVec[ch] <= 1'b1;
        end else if (count == maxVal) begin
          overflow[ch] <= 1'b1;
          doneVec[ch]  <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end

    assign results[ch*CNT_W +: CNT_W] = count;
  end

endmodule

// File: rtl/wilkinson_conv_ctrl.sv
module wilkinson_conv_ctrl
  import wcc_pkg::*;
#(
  parameter int NUM_CH     = 12,
  parameter int CNT_W      = 10,
  parameter int SHORT_W    = 8,
  parameter int SETTLE_CYC = 250,
  parameter int START_DLY  = 250
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gateIn,
  input  logic                    startIn,
  input  logic                    fastClear,
  input  logic                    inhibit,
  input  logic                    sepGateMode,
  input  logic                    shortMode,
  input  logic [NUM_CH-1:0]       rundownActive,
  output logic                    busy,
  output logic                    eoc,
  output logic                    resultValid,
  output logic [NUM_CH*CNT_W-1:0] results,
  output logic [NUM_CH-1:0]       overflow
);

  strobe_t strobes;
  logic    allDone;

  wcc_control #(
    .SETTLE_CYC(SETTLE_CYC),
    .START_DLY (START_DLY)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .gateIn     (gateIn),
    .startIn    (startIn),
    .fastClear  (fastClear),
    .inhibit    (inhibit),
    .sepGateMode(sepGateMode),
    .shortMode  (shortMode),
    .allDone    (allDone),
    .strobes    (strobes),
    .busy       (busy),
    .eoc        (eoc),
    .resultValid(resultValid)
  );

  wcc_datapath #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .SHORT_W(SHORT_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .rundownActive(rundownActive),
    .results      (results),
    .overflow     (overflow),
    .allDone      (allDone)
  );

endmodule

// File: rtl/wcc_checker.sv
module wcc_checker #(
  parameter int NUM_CH  = 12,
  parameter int CNT_W   = 10,
  parameter int SHORT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    gateIn,
  input logic                    startIn,
  input logic                    fastClear,
  input logic                    inhibit,
  input logic                    busy,
  input logic                    eoc,
  input logic                    resultValid,
  input logic [NUM_CH*CNT_W-1:0] results,
  input logic [NUM_CH-1:0]       overflow
);

  localparam logic [CNT_W-1:0] FULL_MAX  = '1;
  localparam logic [CNT_W-1:0] SHORT_MAX = CNT_W'((1 << SHORT_W) - 1);

  // R4: end-of-conversion is a single-cycle pulse
  a_r4_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  // R4: busy has dropped when eoc is seen, and results are marked valid
  a_r4_eoc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (!busy && resultValid));

  // R5: fast clear drops busy and validity in the next cycle
  a_r5_clear_abort: assert property (@(posedge clk) disable iff (!rst_n)
    fastClear |=> (!busy && !resultValid && (overflow == '0) && (results == '0)));

  // R6: an idle block with inhibit high stays idle
  a_r6_inhibit_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inhibit && !fastClear) |=> !busy);

  // R8: held results do not move without acceptance or clear
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && !busy && !fastClear && !gateIn && !startIn)
      |=> ($stable(results) && $stable(overflow)));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R3: an overflowing channel holds a saturated count
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      overflow[ch] |-> (results[ch*CNT_W +: CNT_W] == FULL_MAX ||
                        results[ch*CNT_W +: CNT_W] == SHORT_MAX));
    // R3: overflow only appears during a conversion
    a_r3_ovf_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow[ch]) |-> busy);
  end

endmodule

bind wilkinson_conv_ctrl wcc_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .SHORT_W(SHORT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gateIn     (gateIn),
  .startIn    (startIn),
  .fastClear  (fastClear),
  .inhibit    (inhibit),
  .busy       (busy),
  .eoc        (eoc),
  .resultValid(resultValid),
  .results    (results),
  .overflow   (overflow)
);

// File: tb/sim_wilkinson_conv_ctrl.sv
module sim_wilkinson_conv_ctrl;

  localparam int NCH    = 12;
  localparam int CW     = 10;
  localparam int SETTLE = 8;
  localparam int DLY    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gateIn = 1'b0, startIn = 1'b0, fastClear = 1'b0, inhibit = 1'b0;
  logic sepGateMode = 1'b0, shortMode = 1'b0;
  logic [NCH-1:0] rundownActive = '0;
  logic busy, eoc, resultValid;
  logic [NCH*CW-1:0] results;
  logic [NCH-1:0] overflow;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int lens[NCH];

  always #4 clk = ~clk;  // 125 MHz

  wilkinson_conv_ctrl #(
    .NUM_CH(NCH), .CNT_W(CW), .SHORT_W(8),
    .SETTLE_CYC(SETTLE), .START_DLY(DLY)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .gateIn(gateIn), .startIn(startIn),
    .fastClear(fastClear), .inhibit(inhibit), .sepGateMode(sepGateMode),
    .shortMode(shortMode), .rundownActive(rundownActive), .busy(busy),
    .eoc(eoc), .resultValid(resultValid), .results(results), .overflow(overflow)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // state: 0 idle, 1 settling, 2 start delay, 3 converting
  int mState = 0, mTmr = 0;
  int mCnt[NCH], mDone[NCH], mOvf[NCH];
  int mEoc = 0, mValid = 0, mShort = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mTmr = 0; mEoc = 0; mValid = 0; mShort = 0;
      foreach (mCnt[i]) begin mCnt[i] = 0; mDone[i] = 0; mOvf[i] = 0; end
    end else begin
      int limit;
      bit take, begin_conv, all_done;
      all_done = 1;
      foreach (mDone[i]) if (mDone[i] == 0) all_done = 0;
      take = (mState == 0) && !inhibit && (sepGateMode ? startIn : gateIn);
      begin_conv = !fastClear && ((take && !sepGateMode) || (mState == 2 && mTmr == 0));
      limit = mShort ? 255 : 1023;
      for (int i = 0; i < NCH; i++) begin
        if (fastClear || begin_conv) begin
          mCnt[i] = 0; mDone[i] = 0; mOvf[i] = 0;
        end else if (mState == 3 && mDone[i] == 0) begin
          if (!rundownActive[i]) mDone[i] = 1;
          else if (mCnt[i] == limit) begin mOvf[i] = 1; mDone[i] = 1; end
          else mCnt[i]++;
        end
      end
      mEoc = 0;
      if (fastClear) begin
        mState = 1; mTmr = SETTLE - 1; mValid = 0;
      end else if (mState == 0) begin
        if (take) begin
          mValid = 0; mShort = shortMode;
          if (sepGateMode) begin mState = 2; mTmr = DLY - 1; end
          else mState = 3;
        end
      end else if (mState == 1 || mState == 2) begin
        if (mTmr == 0) mState = (mState == 1) ? 0 : 3;
        else mTmr--;
      end else if (all_done) begin
        mState = 0; mEoc = 1; mValid = 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy", busy, (mState == 2 || mState == 3));
      check("R4 eoc", eoc, mEoc);
      check("R4 resultValid", resultValid, mValid);
      for (int i = 0; i < NCH; i++) begin
        check("R1 count", results[i*CW +: CW], mCnt[i]);
        check("R3 overflow", overflow[i], mOvf[i]);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  // drive one conversion using lens[], offset = extra edges before counting
  task automatic runConv(input bit sep, input bit shrt, input int off);
    int cyc = 0;
    bit seen = 0;
    @(negedge clk);
    sepGateMode = sep; shortMode = shrt;
    if (sep) startIn = 1'b1; else gateIn = 1'b1;
    rundownActive = '1;
    while (!seen && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      gateIn = 1'b0; startIn = 1'b0;
      for (int i = 0; i < NCH; i++) rundownActive[i] = (cyc <= lens[i] + off);
      if (eoc) seen = 1;
    end
    check("R4 eoc seen", seen, 1);
    rundownActive = '0;
  endtask

  task automatic checkResults(input string tag, input int maxv);
    for (int i = 0; i < NCH; i++) begin
      check({tag, " R1 result"}, results[i*CW +: CW], (lens[i] > maxv) ? maxv : lens[i]);
      check({tag, " R3 ovf"}, overflow[i], (lens[i] > maxv) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R2 reset busy", busy, 0);
    check("R4 reset valid", resultValid, 0);
    check("R1 reset results", (results == '0), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: distinct lengths, common gate, including zero length
    for (int i = 0; i < NCH; i++) lens[i] = 7 * i + (i % 3);
    runConv(0, 0, 0);
    checkResults("common", 1023);
    // R8: results hold after eoc, gate while busy ignored later
    repeat (5) @(negedge clk);
    checkResults("R8 hold", 1023);

    // R3: 8-bit mode with saturation
    for (int i = 0; i < NCH; i++) lens[i] = (i < 4) ? 300 : 40 + i;
    lens[4] = 255;
    runConv(0, 1, 0);
    checkResults("short", 255);

    // R3: 10-bit saturation
    for (int i = 0; i < NCH; i++) lens[i] = (i == 2) ? 1100 : 1023 - i;
    runConv(0, 0, 0);
    checkResults("full", 1023);

    // R6: inhibit blocks gate and start
    @(negedge clk); inhibit = 1'b1; gateIn = 1'b1;
    @(negedge clk); gateIn = 1'b0;
    check("R6 gate inhibited", busy, 0);
    sepGateMode = 1'b1; startIn = 1'b1;
    @(negedge clk); startIn = 1'b0; inhibit = 1'b0; sepGateMode = 1'b0;
    check("R6 start inhibited", busy, 0);

    // R8: a second gate during a conversion is ignored
    for (int i = 0; i < NCH; i++) lens[i] = 20 + i;
    @(negedge clk); gateIn = 1'b1; rundownActive = '1;
    @(negedge clk); gateIn = 1'b0;
    check("R2 busy after gate", busy, 1);
    repeat (5) @(negedge clk);
    gateIn = 1'b1;
    @(negedge clk); gateIn = 1'b0;
    check("R8 busy kept", busy, 1);
    repeat (60) @(negedge clk);
    rundownActive = '0;
    repeat (4) @(negedge clk);
    check("R8 idle after", busy, 0);

    // R5: fast clear mid-rundown, lockout then reacceptance
    @(negedge clk); gateIn = 1'b1; rundownActive = '1;
    @(negedge clk); gateIn = 1'b0;
    repeat (30) @(negedge clk);
    fastClear = 1'b1;
    @(negedge clk); fastClear = 1'b0; rundownActive = '0;
    check("R5 busy cleared", busy, 0);
    check("R5 results cleared", (results == '0), 1);
    gateIn = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    check("R5 lockout", busy, 0);
    repeat (3) @(negedge clk);
    gateIn = 1'b0;
    check("R5 accepted after settle", busy, 1);
    repeat (6) @(negedge clk);

    // R7: separate-gate mode; gate ignored, start launches after delay
    @(negedge clk); sepGateMode = 1'b1; gateIn = 1'b1;
    @(negedge clk); gateIn = 1'b0;
    check("R7 gate ignored", busy, 0);
    for (int i = 0; i < NCH; i++) lens[i] = 3 + 5 * i;
    runConv(1, 0, DLY);
    checkResults("R7 sep", 1023);
    sepGateMode = 1'b0;
    repeat (4) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule